// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity

This block joins two eight-bit buses, called side A and side B, through non-inverting buffers. One direction input selects the flow. When it is high, side A drives side B. When it is low, side B drives side A. An active-low enable releases every pin the block could drive. The block has no clock and no state: every output is a combinational function of the current inputs.

A single parity pin changes its role with the direction. While transmitting, the block drives a parity bit computed from the side-A byte. While receiving, it reads that pin as an incoming parity bit, checks the side-B byte against it, and drives a status line that is high when the check passes. A select input chooses between odd and even parity for both jobs.

Each pin that can be bidirectional or released is modelled as separate input, output and output-enable signals, so that a pad ring can be attached outside the block. The data ports carry no valid/ready handshake because the block neither holds nor paces data. The only signals that qualify the data are the output-enable lines.

Top module: `bus_xcvr_parity`

## Requirements
- R1: With `oe_n` low and `dir_tx` high (transmit), `b_oe` is 1, `a_oe` is 0, and `b_out` equals `a_in` bit for bit with no inversion.
- R2: With `oe_n` low and `dir_tx` low (receive), `a_oe` is 1, `b_oe` is 0, and `a_out` equals `b_in` bit for bit with no inversion.
- R3: While `oe_n` is high, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0, whatever the other inputs are.
- R4: In transmit with `odd_sel` = 1, `par_out` is 1 exactly when the number of ones in `a_in` is even, so the nine bits together hold an odd count.
- R5: In transmit with `odd_sel` = 0, `par_out` is 1 exactly when the number of ones in `a_in` is odd, so the nine bits together hold an even count.
- R6: In receive with `odd_sel` = 1, `err_out` is 1 (check passed) exactly when the number of ones in `b_in` plus `par_in` is odd, and 0 otherwise.
- R7: In receive with `odd_sel` = 0, `err_out` is 1 (check passed) exactly when the number of ones in `b_in` plus `par_in` is even, and 0 otherwise.
- R8: The parity pin is driven only while transmitting: `par_oe` equals `b_oe`, and `par_in` has no effect on `par_out`. The status pin is driven only while receiving: `err_oe` equals `a_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1 = side A drives side B; 0 = side B drives side A |
| oe_n | input | 1 | Active-low enable for every driven pin |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_in | input | WIDTH | Level seen on the side-A pins |
| a_out | output | WIDTH | Value driven onto side A |
| a_oe | output | 1 | Drive enable for side A |
| b_in | input | WIDTH | Level seen on the side-B pins |
| b_out | output | WIDTH | Value driven onto side B |
| b_oe | output | 1 | Drive enable for side B |
| par_in | input | 1 | Level seen on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_out | output | 1 | Check status, 1 = parity correct |
| err_oe | output | 1 | Drive enable for the status pin |

## Verification
Two functions work in the same cycle in each direction. While transmitting, the block forwards the data and generates the parity bit. While receiving, it forwards the data and runs the check. The bench applies every byte with both directions, both polarities, both parity-pin levels and both enable states, one combination per clock. Side B carries a byte unrelated to side A, and the bench toggles `par_in` during transmit. A wrong forwarding path, a polarity slip, or a parity result that leaks into the other direction therefore shows up at once. Each cycle, the bench compares every output-enable and every driven value against a reference built from bit counts.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/xor_tree.sv
// Balanced XOR reduction; result is 1 when the input holds an odd count of ones.
module xor_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             odd
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int NODES  = 1 << LEVELS;

  logic [NODES-1:0] padded;
  assign padded = NODES'(vec);

  genvar l, n;
  generate
    for (l = 1; l <= LEVELS; l++) begin : g_lvl
      logic [(NODES >> l)-1:0] node;
      for (n = 0; n < (NODES >> l); n++) begin : g_node
        if (l == 1) begin : g_leaf
          assign node[n] = padded[2*n] ^ padded[2*n+1];
        end else begin : g_inner
          assign node[n] = g_lvl[l-1].node[2*n] ^ g_lvl[l-1].node[2*n+1];
        end
      end
    end
    if (LEVELS == 0) begin : g_single
      assign odd = padded[0];
    end else begin : g_root
      assign odd = g_lvl[LEVELS].node[0];
    end
  endgenerate

  // R4 R5 R6 R7 all rest on this tree reporting the true count parity
  always_comb begin
    a_r4_tree_count: assert (odd == ($countones(vec) % 2 == 1))
      else $error("xor tree disagrees with population count");
  end
endmodule

// File: rtl/lane_steer.sv
// Direction and enable steering for the two data sides.
module lane_steer
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_tx,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             tx_en,
  output logic             rx_en
);
  dir_e mode;
  assign mode = dir_e'(dir_tx);

  always_comb begin
    tx_en = !oe_n && (mode == DIR_TX);
    rx_en = !oe_n && (mode == DIR_RX);
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_lane
      assign b_out[i] = a_in[i];
      assign a_out[i] = b_in[i];
    end
  endgenerate

  always_comb begin
    a_r1_single_source: assert (!(tx_en && rx_en))
      else $error("both sides driven at once");
  end
endmodule

// File: rtl/parity_unit.sv
// Generator on side A and checker on side B, both always computing.
module parity_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             par_in,
  input  logic             odd_sel,
  output logic             gen_bit,
  output logic             chk_ok
);
  logic a_odd;
  logic b_odd;

  xor_tree #(.WIDTH(WIDTH)) i_gen_tree (.vec(a_in), .odd(a_odd));
  xor_tree #(.WIDTH(WIDTH)) i_chk_tree (.vec(b_in), .odd(b_odd));

  // odd select: pad to odd total; even select: pad to even total
  assign gen_bit = a_odd ^ odd_sel;
  // pass when data plus received bit match the chosen polarity
  assign chk_ok  = b_odd ^ par_in ^ ~odd_sel;

  always_comb begin
    a_r6_r7_ok_consistent: assert (chk_ok == ((b_odd ^ par_in) == odd_sel))
      else $error("check result inconsistent with polarity");
  end
endmodule

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_tx,
  input  logic             oe_n,
  input  logic             odd_sel,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_out,
  output logic             err_oe
);
  logic tx_en;
  logic rx_en;

  lane_steer #(.WIDTH(WIDTH)) i_steer (
    .dir_tx(dir_tx), .oe_n(oe_n), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .tx_en(tx_en), .rx_en(rx_en)
  );

  parity_unit #(.WIDTH(WIDTH)) i_parity (
    .a_in(a_in), .b_in(b_in), .par_in(par_in), .odd_sel(odd_sel),
    .gen_bit(par_out), .chk_ok(err_out)
  );

  assign b_oe   = tx_en;
  assign par_oe = tx_en;
  assign a_oe   = rx_en;
  assign err_oe = rx_en;

  always_comb begin
    if (oe_n) begin
      a_r3_all_released: assert (!(a_oe || b_oe || par_oe || err_oe))
        else $error("pin driven while disabled");
    end
    a_r1_one_data_side: assert ($onehot0({a_oe, b_oe}))
      else $error("both data sides enabled");
    if (!oe_n) begin
      a_r2_some_side_on: assert ($countones({a_oe, b_oe}) == 1)
        else $error("enabled but no side driven");
    end
    a_r8_parity_pin_role: assert (par_oe == b_oe && err_oe == a_oe)
      else $error("parity or status pin role wrong for direction");
  end
endmodule

// File: tb/test_bus_xcvr_parity.sv
module test_bus_xcvr_parity;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         dir_tx, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_out, err_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bus_xcvr_parity #(.WIDTH(W)) i_bus_xcvr_parity (
    .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .err_out(err_out), .err_oe(err_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input int d, input logic dir, input logic sel,
                       input logic par, input logic off);
    int ones_a, ones_b;
    logic en, exp_par, exp_ok;
    logic [W-1:0] av, bv;
    av = W'(d);
    bv = W'(d * 37 + 91);
    @(posedge clk);
    #1;
    dir_tx = dir; odd_sel = sel; par_in = par; oe_n = off; a_in = av; b_in = bv;
    @(negedge clk);
    en     = !off;
    ones_a = $countones(av);
    ones_b = $countones(bv) + int'(par);
    exp_par = sel ? (ones_a % 2 == 0) : (ones_a % 2 == 1);
    exp_ok  = sel ? (ones_b % 2 == 1) : (ones_b % 2 == 0);
    if (off) begin
      chk("R3 a_oe", W'(a_oe), '0);
      chk("R3 b_oe", W'(b_oe), '0);
      chk("R3 par_oe", W'(par_oe), '0);
      chk("R3 err_oe", W'(err_oe), '0);
    end else if (dir) begin
      chk("R1 b_oe", W'(b_oe), W'(en));
      chk("R1 a_oe", W'(a_oe), '0);
      chk("R1 b_out", b_out, av);
      chk("R8 par_oe", W'(par_oe), W'(1));
      chk("R8 err_oe", W'(err_oe), '0);
      if (sel) chk("R4 par_out", W'(par_out), W'(exp_par));
      else     chk("R5 par_out", W'(par_out), W'(exp_par));
    end else begin
      chk("R2 a_oe", W'(a_oe), W'(en));
      chk("R2 b_oe", W'(b_oe), '0);
      chk("R2 a_out", a_out, bv);
      chk("R8 par_oe", W'(par_oe), '0);
      chk("R8 err_oe", W'(err_oe), W'(1));
      if (sel) chk("R6 err_out", W'(err_out), W'(exp_ok));
      else     chk("R7 err_out", W'(err_out), W'(exp_ok));
    end
  endtask

  initial begin
    dir_tx = 1'b1; oe_n = 1'b1; odd_sel = 1'b1; par_in = 1'b0;
    a_in = '0; b_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // start-up state: disabled, nothing driven (R3)
    chk("R3 idle a_oe", W'(a_oe), '0);
    chk("R3 idle b_oe", W'(b_oe), '0);
    // R8: parity pin input must not disturb generated bit (same data, both par_in)
    apply(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int d = 0; d < 256; d++)
      for (int m = 0; m < 16; m++)
        apply(d, m[0], m[1], m[2], m[3]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule